// File: doc/BRIEF.md
# Activity-Driven Control Pin Sequencer

This block produces a 32-bit word that drives the control pins of a radio front end, chosen automatically from what the radio is doing. Two status levels come in: one saying that the transmit FIFO holds data, and one saying that reception is active. The transmit level does not act at once. A programmable start delay postpones the switch into the transmitting state after data arrives. A separate programmable end delay postpones the switch out of that state after the FIFO drains.

The delayed transmit flag and the receive level together form a two-bit state index. That index selects one word from a bank of sixteen software-written 32-bit registers. The chosen word is registered onto the output. Downstream pin logic splits the word into its transmit and receive halves. Software fills the bank through a simple synchronous write/read port. Only the four lowest words take part in the selection.

Top module: `trx_pin_switch`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `pins_out`, `mode_idx` and `cfg_rdata` are zero, and every one of the sixteen bank words reads back as zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` in the word at `cfg_addr` at that clock edge. A read returns the word at `cfg_addr` on `cfg_rdata` one edge later. The sixteen words are independent of each other.
- R3: The state index is {receive level, delayed transmit flag}: 0 means idle, 1 transmit only, 2 receive only, 3 full duplex. One edge after the index takes a value, `mode_idx` shows it and `pins_out` shows the bank word with that number.
- R4: If `tx_fifo_busy` is first sampled high at edge k while the flag is clear, with start delay D, the flag sets at edge k+D. `mode_idx` bit 0 then becomes 1 at edge k+D+1.
- R5: If `tx_fifo_busy` is first sampled low at edge k while the flag is set, with end delay E, the flag clears at edge k+E. `mode_idx` bit 0 then becomes 0 at edge k+E+1.
- R6: A delay value of zero makes the flag follow `tx_fifo_busy` at the very edge where the change is first sampled.
- R7: If `tx_fifo_busy` returns to the flag's value before a pending delay expires, that transition is cancelled. The count starts afresh on the next change.
- R8: Writes to words 4 to 15 never change `pins_out`.
- R9: `rx_busy` acts without delay: a change sampled at edge k appears in `mode_idx` bit 1 and in `pins_out` at that same edge.
- R10: A write to the word that is currently selected appears on `pins_out` one edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Bank write strobe |
| cfg_addr | input | 4 | Bank word address for write and read |
| cfg_wdata | input | 32 | Bank write data |
| cfg_rdata | output | 32 | Registered bank read data |
| tx_start_dly | input | 8 | Cycles from FIFO data arrival to transmit switch |
| tx_end_dly | input | 8 | Cycles from FIFO empty to leaving transmit |
| tx_fifo_busy | input | 1 | Transmit FIFO holds data |
| rx_busy | input | 1 | Reception active |
| mode_idx | output | 2 | Registered state index in use |
| pins_out | output | 32 | Registered control pin word |

## Verification
The properties treat `tx_fifo_busy` and `rx_busy` as levels that are synchronous to `clk`. They also assume that the delay inputs are meaningful whenever they are sampled. The transition rules are checked edge by edge: the flag changes only when it disagrees with the FIFO level, and it always changes at once when the applicable delay is zero. The stimulus changes every input only at the falling clock edge. It reprograms the delays only while the flag already agrees with the FIFO level, so no countdown ever sees its limit move underneath it.

// File: rtl/trxsw_pkg.sv
package trxsw_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_TX   = 2'd1,
    MODE_RX   = 2'd2,
    MODE_FULL = 2'd3
  } trx_mode_e;

  function automatic trx_mode_e make_mode(input logic rx_level, input logic tx_flag);
    return trx_mode_e'({rx_level, tx_flag});
  endfunction

endpackage

// File: rtl/trxsw_regbank.sv
module trxsw_regbank #(
  parameter int N_WORDS = 16,
  parameter int WORD_W  = 32,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_cfg,
  output logic [WORD_W-1:0] rdata_cfg,
  input  logic [ADDR_W-1:0] raddr_sel,
  output logic [WORD_W-1:0] rdata_sel
);

  logic [WORD_W-1:0] word_q [N_WORDS];

  // one register per word, each with its own write decode
  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        word_q[g] <= '0;
      end else if (we && (waddr == ADDR_W'(g))) begin
        word_q[g] <= wdata;
      end
    end
  end

  // two registered read ports: software and state selection
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_cfg <= '0;
      rdata_sel <= '0;
    end else begin
      rdata_cfg <= word_q[raddr_cfg];
      rdata_sel <= word_q[raddr_sel];
    end
  end

endmodule

// File: rtl/trxsw_switch_delay.sv
module trxsw_switch_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic [DLY_W-1:0] start_dly,
  input  logic [DLY_W-1:0] end_dly,
  output logic             flag
);

  logic             flag_q;
  logic [DLY_W-1:0] wait_q;
  logic             differ;
  logic [DLY_W-1:0] limit;

  assign differ = busy ^ flag_q;
  // rising flag waits on the start delay, falling flag on the end delay
  assign limit  = flag_q ? end_dly : start_dly;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      wait_q <= '0;
    end else if (!differ) begin
      wait_q <= '0;            // agreement cancels any pending change
    end else if (wait_q >= limit) begin
      flag_q <= busy;
      wait_q <= '0;
    end else begin
      wait_q <= wait_q + 1'b1;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/trx_pin_switch.sv
module trx_pin_switch #(
  parameter int N_WORDS = 16,
  parameter int WORD_W  = 32,
  parameter int DLY_W   = 8,
  localparam int ADDR_W = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic [DLY_W-1:0]  tx_start_dly,
  input  logic [DLY_W-1:0]  tx_end_dly,
  input  logic              tx_fifo_busy,
  input  logic              rx_busy,
  output logic [1:0]        mode_idx,
  output logic [WORD_W-1:0] pins_out
);
  import trxsw_pkg::*;

  logic      tx_flag;
  trx_mode_e mode_now;
  logic [1:0] mode_q;

  trxsw_switch_delay #(.DLY_W(DLY_W)) i_delay (
    .clk       (clk),
    .rst       (rst),
    .busy      (tx_fifo_busy),
    .start_dly (tx_start_dly),
    .end_dly   (tx_end_dly),
    .flag      (tx_flag)
  );

  assign mode_now = make_mode(rx_busy, tx_flag);

  trxsw_regbank #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) i_bank (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .waddr     (cfg_addr),
    .wdata     (cfg_wdata),
    .raddr_cfg (cfg_addr),
    .rdata_cfg (cfg_rdata),
    .raddr_sel (ADDR_W'(mode_now)),
    .rdata_sel (pins_out)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 2'd0;
    else     mode_q <= mode_now;
  end

  assign mode_idx = mode_q;

endmodule

// File: rtl/trxsw_checker.sv
module trxsw_checker #(
  parameter int WORD_W = 32,
  parameter int DLY_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_fifo_busy,
  input logic              rx_busy,
  input logic [DLY_W-1:0]  tx_start_dly,
  input logic [DLY_W-1:0]  tx_end_dly,
  input logic              tx_flag,
  input logic [1:0]        mode_idx,
  input logic [WORD_W-1:0] pins_out
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pins_out == '0) && (mode_idx == 2'd0) && !tx_flag);

  assert_rx_immediate_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> mode_idx[1] == $past(rx_busy));

  assert_flag_to_index_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> mode_idx[0] == $past(tx_flag));

  assert_rise_needs_data_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_flag) |-> $past(tx_fifo_busy));

  assert_fall_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_flag) |-> !$past(tx_fifo_busy));

  assert_zero_start_R6: assert property (@(posedge clk) disable iff (rst)
    (!tx_flag && tx_fifo_busy && tx_start_dly == '0) |=> tx_flag);

  assert_zero_end_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_flag && !tx_fifo_busy && tx_end_dly == '0) |=> !tx_flag);

  assert_hold_on_agree_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_flag == tx_fifo_busy) |=> $stable(tx_flag));

endmodule

bind trx_pin_switch trxsw_checker #(.WORD_W(WORD_W), .DLY_W(DLY_W)) i_checker (
  .clk          (clk),
  .rst          (rst),
  .tx_fifo_busy (tx_fifo_busy),
  .rx_busy      (rx_busy),
  .tx_start_dly (tx_start_dly),
  .tx_end_dly   (tx_end_dly),
  .tx_flag      (tx_flag),
  .mode_idx     (mode_idx),
  .pins_out     (pins_out)
);

// File: tb/test_trx_pin_switch.sv
module test_trx_pin_switch;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  tx_start_dly = '0;
  logic [7:0]  tx_end_dly = '0;
  logic        tx_fifo_busy = 1'b0;
  logic        rx_busy = 1'b0;
  logic [1:0]  mode_idx;
  logic [31:0] pins_out;

  int errors = 0;
  int checks = 0;
  logic [31:0] shadow [16];

  always #4 clk = ~clk;

  trx_pin_switch i_trx_pin_switch (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_start_dly(tx_start_dly), .tx_end_dly(tx_end_dly),
    .tx_fifo_busy(tx_fifo_busy), .rx_busy(rx_busy),
    .mode_idx(mode_idx), .pins_out(pins_out)
  );

  function automatic logic [31:0] pattern(input int i, input int salt);
    return (32'h9E37_79B9 * (i + 3 + salt)) ^ {i[3:0], 28'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write_word(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
    shadow[a] = d;
  endtask

  task automatic read_check(input string req, input int a, input logic [31:0] exp);
    cfg_addr = 4'(a);
    tick(1);
    check(req, cfg_rdata, exp);
  endtask

  // drive flag to a level with zero delay and let outputs settle
  task automatic force_flag(input logic v);
    tx_start_dly = '0; tx_end_dly = '0; tx_fifo_busy = v;
    tick(3);
  endtask

  initial begin
    tick(3);
    // R1: reset state
    check("R1 pins", pins_out, 32'h0);
    check("R1 mode", {30'h0, mode_idx}, 32'h0);
    check("R1 rdata", cfg_rdata, 32'h0);
    rst = 1'b0;
    for (int a = 0; a < 16; a++) begin
      shadow[a] = '0;
      read_check("R1 word zero", a, 32'h0);
    end

    // R2: fill and read back all words
    for (int a = 0; a < 16; a++) write_word(a, pattern(a, 0));
    for (int a = 15; a >= 0; a--) read_check("R2 readback", a, pattern(a, 0));

    // R3/R9: sweep all four states
    for (int m = 0; m < 4; m++) begin
      force_flag(m[0]);
      rx_busy = m[1];
      tick(1);
      check("R9 rx bit at next edge", {30'h0, mode_idx}, 32'(m));
      check("R3 selected word", pins_out, shadow[m]);
    end

    // R4/R6: start delay sweep
    rx_busy = 1'b0;
    for (int d = 0; d < 6; d++) begin
      force_flag(1'b0);
      tx_start_dly = 8'(d);
      tx_fifo_busy = 1'b1;
      tick(d + 1);
      check(d == 0 ? "R6 start zero not early" : "R4 start not early",
            {31'h0, mode_idx[0]}, 32'h0);
      tick(1);
      check(d == 0 ? "R6 start zero" : "R4 start on time", {31'h0, mode_idx[0]}, 32'h1);
      check("R4 transmit word", pins_out, shadow[1]);
    end

    // R5/R6: end delay sweep
    for (int e = 0; e < 6; e++) begin
      force_flag(1'b1);
      tx_end_dly = 8'(e);
      tx_fifo_busy = 1'b0;
      tick(e + 1);
      check(e == 0 ? "R6 end zero not early" : "R5 end not early",
            {31'h0, mode_idx[0]}, 32'h1);
      tick(1);
      check(e == 0 ? "R6 end zero" : "R5 end on time", {31'h0, mode_idx[0]}, 32'h0);
      check("R5 idle word", pins_out, shadow[0]);
    end

    // R7: cancelled start, then cancelled end
    begin
      int bad;
      force_flag(1'b0);
      tx_start_dly = 8'd4;
      tx_fifo_busy = 1'b1;
      tick(3);
      tx_fifo_busy = 1'b0;
      bad = 0;
      for (int k = 0; k < 10; k++) begin tick(1); if (mode_idx[0]) bad++; end
      check("R7 start cancelled", 32'(bad), 32'h0);
      // a fresh request counts the full delay again
      tx_fifo_busy = 1'b1;
      tick(5);
      check("R7 restart not early", {31'h0, mode_idx[0]}, 32'h0);
      tick(1);
      check("R7 restart full delay", {31'h0, mode_idx[0]}, 32'h1);

      tx_end_dly = 8'd4;
      tx_fifo_busy = 1'b0;
      tick(2);
      tx_fifo_busy = 1'b1;
      bad = 0;
      for (int k = 0; k < 10; k++) begin tick(1); if (!mode_idx[0]) bad++; end
      check("R7 end cancelled", 32'(bad), 32'h0);
    end

    // R8: words 4..15 do not affect output, in every state
    for (int m = 0; m < 4; m++) begin
      int bad;
      force_flag(m[0]);
      rx_busy = m[1];
      tick(1);
      bad = 0;
      for (int a = 4; a < 16; a++) begin
        write_word(a, pattern(a, 7 + m));
        tick(1);
        if (pins_out !== shadow[m]) bad++;
      end
      check("R8 upper words ignored", 32'(bad), 32'h0);
    end

    // R10: rewrite the selected word
    for (int m = 0; m < 4; m++) begin
      force_flag(m[0]);
      rx_busy = m[1];
      tick(1);
      write_word(m, pattern(m, 20));
      check("R10 not before write visible", pins_out, pattern(m, 0));
      tick(1);
      check("R10 new word on pins", pins_out, pattern(m, 20));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule